// File: doc/BRIEF.md
# Sensor power mode sequencer

This block chooses the power state of an optical navigation sensor from the time elapsed since motion was last reported. It holds a single inactivity timer, counted in prescaled time ticks. As that timer passes three increasing thresholds, the sensor steps from Run down to Rest1, then Rest2, then Rest3. Each state has its own frame period, and a frame strobe pulses once per period so that the capture logic knows when to take an image.

A reported-motion pulse brings an automatic state straight back to Run and restarts the timer. A 2-bit forced-rest field can pin the block in any of the three rest states, whatever the timer reads. When the field returns to zero the block resumes in Run with a fresh timer. Every timeout and period is a parameter in ticks, so a bench can run with small values.

The state machine has seven named states:

- ST_RUN, ST_AUTO1, ST_AUTO2 and ST_AUTO3 are the automatic states.
- ST_HOLD1, ST_HOLD2 and ST_HOLD3 are the forced states.

Transitions, with priority from highest to lowest:

- Any state goes to ST_HOLDn when the field is nonzero.
- ST_HOLDn goes to ST_RUN when the field is cleared.
- Any automatic state goes to ST_RUN on motion.
- ST_RUN goes to ST_AUTO1, ST_AUTO1 to ST_AUTO2, and ST_AUTO2 to ST_AUTO3, each when the timer reaches the next threshold.
- ST_AUTO3 holds.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is asserted and just after it is released, the mode status is Run (00), the frame strobe is low and the inactivity timer is zero.
- R2: The mode status encodes Run as 00, Rest1 as 01, Rest2 as 10 and Rest3 as 11, and it follows the state register with no added delay.
- R3: With the forced-rest field at 00 and no motion, the mode moves Run to Rest1, Rest1 to Rest2 and Rest2 to Rest3, one step at a time. Each step happens on the clock after the inactivity timer reaches TMO_R1, TMO_R2 or TMO_R3 respectively. Rest3 then holds.
- R4: A motion pulse while the forced-rest field is 00 sets the mode to Run on the next clock and clears the inactivity timer to zero.
- R5: A forced-rest field of 01, 10 or 11 sets the mode to Rest1, Rest2 or Rest3 respectively on the next clock. The mode holds there regardless of ticks or motion pulses, and a change between nonzero values takes effect on the next clock.
- R6: When the forced-rest field returns to 00 from a forced state, the mode becomes Run on the next clock. The inactivity timer starts again from zero, because it is kept clear while forcing is active.
- R7: In a steady mode, the frame strobe pulses once every PER_RUN, PER_R1, PER_R2 or PER_R3 ticks (Run, Rest1, Rest2, Rest3). The pulse appears on the clock after the tick that completes the period.
- R8: The frame strobe is high for one cycle at a time. A mode change restarts the frame count from zero and suppresses the strobe on the following clock.
- R9: Only clocks with the tick input high advance the inactivity timer or the frame count. With no ticks, the mode and the timer hold and no strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| motion_seen | input | 1 | One-cycle pulse: motion has been reported |
| force_sel | input | 2 | Forced-rest field: 00 automatic, 01/10/11 force Rest1/Rest2/Rest3 |
| tick | input | 1 | Prescaled time tick, one-cycle enable |
| frame_stb | output | 1 | One-cycle pulse at the frame period of the current mode |
| mode_out | output | 2 | Current power mode: 00 Run, 01 Rest1, 10 Rest2, 11 Rest3 |

## Verification
The assertions check the following on every cycle: motion returns the block to Run, the forced field takes hold on the next clock, and clearing the field leads to Run. They also check that automatic movement only ever steps down one level or stays put, that the timer clears and holds correctly, and that the strobe is a single-cycle pulse tied to a tick. Only the bench scenarios can show the exact thresholds at which each downshift lands, and the exact strobe count per period in each mode. The same goes for timer behaviour across forced periods and pacing under sparse ticks. These are compared against a behavioural reference on every clock.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_REST1 = 2'b01,
        MODE_REST2 = 2'b10,
        MODE_REST3 = 2'b11
    } pwr_mode_e;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_AUTO1 = 3'd1,
        ST_AUTO2 = 3'd2,
        ST_AUTO3 = 3'd3,
        ST_HOLD1 = 3'd4,
        ST_HOLD2 = 3'd5,
        ST_HOLD3 = 3'd6
    } seq_state_e;

endpackage

// File: rtl/pms_idle_timer.sv
// Counts ticks since the last clear, saturating at LIMIT.
module pms_idle_timer #(
    parameter int LIMIT = 1008000,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (tick && (count != LIM)) begin
            count <= count + 1'b1;
        end
    end

    // R4/R6: a clear leaves the timer at zero
    a_r4_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

    // R9: without a tick or a clear the timer holds
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(count));

    // R3: the timer never passes its saturation value
    a_r3_idle_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (count == LIM) |=> (count == LIM || count == '0));

endmodule

// File: rtl/pms_mode_fsm.sv
// Power mode state machine: automatic downshift plus forced hold.
module pms_mode_fsm
    import pms_pkg::*;
#(
    parameter int CW     = 20,
    parameter int TMO_R1 = 474,
    parameter int TMO_R2 = 16800,
    parameter int TMO_R3 = 1008000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          motion_seen,
    input  logic [1:0]    force_sel,
    input  logic [CW-1:0] idle_cnt,
    output pwr_mode_e     mode
);
    localparam logic [CW-1:0] LIM1 = CW'(TMO_R1);
    localparam logic [CW-1:0] LIM2 = CW'(TMO_R2);
    localparam logic [CW-1:0] LIM3 = CW'(TMO_R3);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       in_hold;
    logic       forcing;

    assign forcing = (force_sel != 2'b00);
    assign in_hold = (state_q == ST_HOLD1) || (state_q == ST_HOLD2) ||
                     (state_q == ST_HOLD3);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (forcing) begin
            unique case (force_sel)
                2'b01:   state_d = ST_HOLD1;
                2'b10:   state_d = ST_HOLD2;
                default: state_d = ST_HOLD3;
            endcase
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (!motion_seen && idle_cnt >= LIM1) state_d = ST_AUTO1;
                end
                ST_AUTO1: begin
                    if (motion_seen)            state_d = ST_RUN;
                    else if (idle_cnt >= LIM2)  state_d = ST_AUTO2;
                end
                ST_AUTO2: begin
                    if (motion_seen)            state_d = ST_RUN;
                    else if (idle_cnt >= LIM3)  state_d = ST_AUTO3;
                end
                ST_AUTO3: begin
                    if (motion_seen)            state_d = ST_RUN;
                end
                ST_HOLD1, ST_HOLD2, ST_HOLD3: state_d = ST_RUN;
                default:                      state_d = ST_RUN;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:             mode = MODE_RUN;
            ST_AUTO1, ST_HOLD1: mode = MODE_REST1;
            ST_AUTO2, ST_HOLD2: mode = MODE_REST2;
            ST_AUTO3, ST_HOLD3: mode = MODE_REST3;
            default:            mode = MODE_RUN;
        endcase
    end

    a_r4_motion_run: assert property (@(posedge clk) disable iff (!rst_n)
        (motion_seen && !forcing) |=> (mode == MODE_RUN));

    a_r5_forced_take: assert property (@(posedge clk) disable iff (!rst_n)
        forcing |=> (mode == $past(force_sel)));

    a_r6_release_run: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && !forcing) |=> (mode == MODE_RUN));

    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!forcing && !motion_seen && !in_hold) |=>
            ((mode == $past(mode)) || (int'(mode) == int'($past(mode)) + 1)));

endmodule

// File: rtl/pms_frame_timer.sv
// Frame period counter; strobe at the period of the current mode.
module pms_frame_timer
    import pms_pkg::*;
#(
    parameter int PER_RUN = 33,
    parameter int PER_R1  = 33,
    parameter int PER_R2  = 164,
    parameter int PER_R3  = 820,
    parameter int FW      = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  pwr_mode_e mode,
    output logic      frame_stb
);
    localparam logic [FW-1:0] LAST_RUN = FW'(PER_RUN - 1);
    localparam logic [FW-1:0] LAST_R1  = FW'(PER_R1 - 1);
    localparam logic [FW-1:0] LAST_R2  = FW'(PER_R2 - 1);
    localparam logic [FW-1:0] LAST_R3  = FW'(PER_R3 - 1);

    logic [FW-1:0] cnt_q;
    logic [FW-1:0] last_val;
    pwr_mode_e     seen_q;
    logic          restart;

    always_comb begin
        unique case (mode)
            MODE_RUN:   last_val = LAST_RUN;
            MODE_REST1: last_val = LAST_R1;
            MODE_REST2: last_val = LAST_R2;
            MODE_REST3: last_val = LAST_R3;
            default:    last_val = LAST_RUN;
        endcase
    end

    assign restart = (mode != seen_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            seen_q    <= MODE_RUN;
            frame_stb <= 1'b0;
        end else if (restart) begin
            cnt_q     <= '0;
            seen_q    <= mode;
            frame_stb <= 1'b0;
        end else if (tick) begin
            if (cnt_q >= last_val) begin
                cnt_q     <= '0;
                frame_stb <= 1'b1;
            end else begin
                cnt_q     <= cnt_q + 1'b1;
                frame_stb <= 1'b0;
            end
        end else begin
            frame_stb <= 1'b0;
        end
    end

    a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> !frame_stb);

    a_r8_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !frame_stb);

    a_r9_stb_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> $past(tick));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int PER_RUN = 2,
    parameter int PER_R1  = 33,
    parameter int PER_R2  = 164,
    parameter int PER_R3  = 820,
    parameter int TMO_R1  = 474,
    parameter int TMO_R2  = 16800,
    parameter int TMO_R3  = 1008000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       motion_seen,
    input  logic [1:0] force_sel,
    input  logic       tick,
    output logic       frame_stb,
    output logic [1:0] mode_out
);
    localparam int PER_A   = (PER_RUN > PER_R1) ? PER_RUN : PER_R1;
    localparam int PER_B   = (PER_R2 > PER_R3) ? PER_R2 : PER_R3;
    localparam int PER_MAX = (PER_A > PER_B) ? PER_A : PER_B;
    localparam int FW      = $clog2(PER_MAX + 1);
    localparam int CW      = $clog2(TMO_R3 + 1);

    logic [CW-1:0] idle_cnt;
    logic          idle_clr;
    pwr_mode_e     mode;

    assign idle_clr = motion_seen || (force_sel != 2'b00);

    pms_idle_timer #(.LIMIT(TMO_R3), .CW(CW)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idle_clr),
        .tick  (tick),
        .count (idle_cnt)
    );

    pms_mode_fsm #(
        .CW(CW), .TMO_R1(TMO_R1), .TMO_R2(TMO_R2), .TMO_R3(TMO_R3)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .motion_seen (motion_seen),
        .force_sel   (force_sel),
        .idle_cnt    (idle_cnt),
        .mode        (mode)
    );

    pms_frame_timer #(
        .PER_RUN(PER_RUN), .PER_R1(PER_R1), .PER_R2(PER_R2),
        .PER_R3(PER_R3), .FW(FW)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .frame_stb (frame_stb)
    );

    assign mode_out = mode;

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mode_out == 2'b00 && !frame_stb && idle_cnt == '0));

endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P0 = 2, P1 = 3, P2 = 4, P3 = 5;
    localparam int T1 = 6, T2 = 12, T3 = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       motion_seen = 1'b0;
    logic [1:0] force_sel = 2'b00;
    logic       tick = 1'b0;
    logic       frame_stb;
    logic [1:0] mode_out;

    pwr_mode_seq #(
        .PER_RUN(P0), .PER_R1(P1), .PER_R2(P2), .PER_R3(P3),
        .TMO_R1(T1), .TMO_R2(T2), .TMO_R3(T3)
    ) uut (
        .clk(clk), .rst_n(rst_n), .motion_seen(motion_seen),
        .force_sel(force_sel), .tick(tick),
        .frame_stb(frame_stb), .mode_out(mode_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int stb_count = 0;
    bit done = 1'b0;

    // behavioural reference
    int m_idle = 0, m_mode = 0, m_fcnt = 0, m_last = 0, old_idle = 0;
    bit m_hold = 1'b0, m_stb = 1'b0;

    function automatic int period_of(int m);
        case (m)
            0: return P0;
            1: return P1;
            2: return P2;
            default: return P3;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idle = 0; m_mode = 0; m_fcnt = 0; m_last = 0;
            m_hold = 1'b0; m_stb = 1'b0;
        end else begin
            if (m_mode != m_last) begin
                m_last = m_mode; m_fcnt = 0; m_stb = 1'b0;
            end else if (tick) begin
                if (m_fcnt >= period_of(m_mode) - 1) begin
                    m_fcnt = 0; m_stb = 1'b1;
                end else begin
                    m_fcnt++; m_stb = 1'b0;
                end
            end else begin
                m_stb = 1'b0;
            end
            old_idle = m_idle;
            if (motion_seen || force_sel != 2'b00) m_idle = 0;
            else if (tick && m_idle < T3) m_idle++;
            if (force_sel != 2'b00) begin
                m_mode = int'(force_sel); m_hold = 1'b1;
            end else if (m_hold) begin
                m_mode = 0; m_hold = 1'b0;
            end else if (motion_seen) begin
                m_mode = 0;
            end else if (m_mode == 0 && old_idle >= T1) begin
                m_mode = 1;
            end else if (m_mode == 1 && old_idle >= T2) begin
                m_mode = 2;
            end else if (m_mode == 2 && old_idle >= T3) begin
                m_mode = 3;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(mode_out == 2'(m_mode), "R2 mode vs reference", int'(mode_out), m_mode);
            chk(frame_stb == m_stb, "R7/R8 strobe vs reference", int'(frame_stb), int'(m_stb));
            if (frame_stb) stb_count++;
        end
    end

    task automatic run(input int n, input int div);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = (div != 0) && (i % div == 0);
        end
    endtask

    task automatic pulse_motion();
        @(negedge clk);
        motion_seen = 1'b1;
        tick = 1'b0;
        @(negedge clk);
        motion_seen = 1'b0;
    endtask

    task automatic set_force(input logic [1:0] v);
        @(negedge clk);
        force_sel = v;
        tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mode_out == 2'b00, "R1 mode in reset", int'(mode_out), 0);
        chk(frame_stb == 1'b0, "R1 strobe in reset", int'(frame_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mode_out == 2'b00, "R1 mode after reset", int'(mode_out), 0);

        // R9: no ticks, nothing moves
        stb_count = 0;
        run(60, 0);
        chk(mode_out == 2'b00, "R9 mode without ticks", int'(mode_out), 0);
        chk(stb_count == 0, "R9 strobes without ticks", stb_count, 0);

        // R3: automatic downshift
        run(8, 1);
        chk(mode_out == 2'b01, "R3 Rest1 after TMO_R1", int'(mode_out), 1);
        run(8, 1);
        chk(mode_out == 2'b10, "R3 Rest2 after TMO_R2", int'(mode_out), 2);
        run(20, 1);
        chk(mode_out == 2'b11, "R3 Rest3 after TMO_R3", int'(mode_out), 3);
        run(30, 1);
        chk(mode_out == 2'b11, "R3 Rest3 holds", int'(mode_out), 3);

        // R7: strobe rate in Rest3
        stb_count = 0;
        run(25, 1);
        chk(stb_count == 25 / P3, "R7 Rest3 strobe count", stb_count, 25 / P3);

        // R4: motion returns to Run and restarts timer
        pulse_motion();
        chk(mode_out == 2'b00, "R4 motion returns Run", int'(mode_out), 0);
        run(5, 1);
        chk(mode_out == 2'b00, "R4 timer restarted", int'(mode_out), 0);

        // R5: forced rest
        set_force(2'b10);
        chk(mode_out == 2'b10, "R5 force Rest2", int'(mode_out), 2);
        pulse_motion();
        chk(mode_out == 2'b10, "R5 motion ignored in hold", int'(mode_out), 2);
        run(50, 1);
        chk(mode_out == 2'b10, "R5 hold against timer", int'(mode_out), 2);
        stb_count = 0;
        run(24, 1);
        chk(stb_count == 24 / P2, "R7 Rest2 strobe count", stb_count, 24 / P2);
        set_force(2'b01);
        chk(mode_out == 2'b01, "R5 force Rest1", int'(mode_out), 1);
        set_force(2'b11);
        chk(mode_out == 2'b11, "R5 force Rest3", int'(mode_out), 3);

        // R6: release
        set_force(2'b00);
        chk(mode_out == 2'b00, "R6 release to Run", int'(mode_out), 0);
        run(5, 1);
        chk(mode_out == 2'b00, "R6 timer cleared by hold", int'(mode_out), 0);

        // R9: sparse ticks pace the timer
        pulse_motion();
        run(30, 3);
        chk(mode_out == 2'b01, "R9 sparse ticks reach Rest1 only", int'(mode_out), 1);

        // R8: change of mode then steady Run strobes
        pulse_motion();
        chk(frame_stb == 1'b0, "R8 no strobe after mode change", int'(frame_stb), 0);
        stb_count = 0;
        run(4, 1);
        chk(mode_out == 2'b00, "R7 still Run", int'(mode_out), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule